// File: doc/BRIEF.md
# Acknowledged Interval Interrupt Timer

This block measures a fixed interval in clock cycles and then signals the CPU with a single interrupt line. Once the interval has run out, the line goes high and stays high as a level until the CPU returns a acknowledge pulse. That acknowledge drops the line and starts a fresh interval from zero. The timer does not reload on its own: while an interrupt is waiting, the count is frozen, so every interval is measured from the acknowledge that ended the previous one.

The interval is set at build time from two parameters, the clock frequency in hertz and the period in microseconds. The default period is 10 ms. An acknowledge that arrives while no interrupt is waiting simply restarts the count. An acknowledge held high for several cycles keeps the count at zero until it is released.

Top module: `interval_alarm`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, the interrupt output is low, and the count starts from zero.
- R2: With no acknowledge, the interrupt output is first seen high after exactly N rising clock edges following the edge on which reset was last sampled high, where N is the interval.
- R3: Once high, the interrupt output stays high on every cycle for as long as the acknowledge input stays low.
- R4: An acknowledge sampled while the interrupt is high makes the output low on the next cycle, and the next interrupt appears exactly N edges after that acknowledge edge.
- R5: The time the interrupt waits before being acknowledged has no effect on the next interval: it is always N edges from the acknowledge.
- R6: An acknowledge sampled while counting with no interrupt pending restarts the count, so the interrupt appears N edges after that acknowledge edge.
- R7: An acknowledge held high for several cycles keeps the output low throughout, and N is counted from the last edge on which it was sampled high.
- R8: An acknowledge sampled on the same edge on which the interval would run out takes priority: the output stays low and a full new interval begins.
- R9: N equals the clock frequency in hertz multiplied by the period in microseconds and divided by 1,000,000 (with a floor of 2); the default period is 10,000 microseconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ack_i | input | 1 | Acknowledge from the CPU; clears the interrupt and restarts the interval |
| irq_o | output | 1 | Interrupt level to the CPU |

## Verification
The timer is first driven with directed patterns: a free run from reset, long waits before acknowledging, an acknowledge in the middle of an interval, an acknowledge held for several cycles, and one placed on the very edge of expiry. Each measures the distance from the last restart to the rising interrupt, which separates a timer that measures from the acknowledge from one that reloads on expiry or misses the ack-versus-expiry priority. A long run with sparse random acknowledges then compares the output on every cycle against a cycle model built from the requirements, exposing off-by-one counts and lost or spurious interrupts.

// File: rtl/interval_alarm_pkg.sv
package interval_alarm_pkg;

    // What the timer does on the next rising edge.
    typedef enum logic [1:0] {
        STEP_COUNT   = 2'd0,  // advance the count
        STEP_EXPIRE  = 2'd1,  // interval done: raise the interrupt
        STEP_RESTART = 2'd2,  // acknowledge: clear and start over
        STEP_WAIT    = 2'd3   // interrupt pending: hold
    } step_e;

    localparam longint unsigned US_PER_SECOND = 64'd1_000_000;
    localparam longint unsigned MIN_INTERVAL  = 64'd2;

    // Interval length in clock cycles for a given clock and period.
    function automatic longint unsigned cycles_for_period(
        input longint unsigned clk_hz,
        input longint unsigned period_us
    );
        longint unsigned raw;
        raw = (clk_hz * period_us) / US_PER_SECOND;
        return (raw < MIN_INTERVAL) ? MIN_INTERVAL : raw;
    endfunction

endpackage

// File: rtl/interval_alarm_step.sv
module interval_alarm_step
    import interval_alarm_pkg::*;
(
    input  logic  ack_i,
    input  logic  pending_i,
    input  logic  at_last_i,
    output step_e step_o
);

    // Acknowledge wins over everything, including a same-edge expiry.
    always_comb begin
        if (ack_i) begin
            step_o = STEP_RESTART;
        end else if (pending_i) begin
            step_o = STEP_WAIT;
        end else if (at_last_i) begin
            step_o = STEP_EXPIRE;
        end else begin
            step_o = STEP_COUNT;
        end
    end

endmodule

// File: rtl/interval_alarm_count.sv
module interval_alarm_count
    import interval_alarm_pkg::*;
#(
    parameter int unsigned INTERVAL = 1_000_000,
    localparam int unsigned CW      = $clog2(INTERVAL),
    localparam logic [CW-1:0] LAST  = CW'(INTERVAL - 1)
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  step_e step_i,
    output logic  at_last_o
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else begin
            unique case (step_i)
                STEP_COUNT:   count_q <= count_q + 1'b1;
                STEP_WAIT:    count_q <= count_q;
                STEP_EXPIRE,
                STEP_RESTART: count_q <= '0;
                default:      count_q <= '0;
            endcase
        end
    end

    assign at_last_o = (count_q == LAST);

endmodule

// File: rtl/interval_alarm_flag.sv
module interval_alarm_flag
    import interval_alarm_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  step_e step_i,
    output logic  pending_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pending_o <= 1'b0;
        end else begin
            unique case (step_i)
                STEP_EXPIRE:  pending_o <= 1'b1;
                STEP_RESTART: pending_o <= 1'b0;
                default:      pending_o <= pending_o;
            endcase
        end
    end

endmodule

// File: rtl/interval_alarm.sv
module interval_alarm
    import interval_alarm_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 64'd100_000_000,
    parameter longint unsigned PERIOD_US   = 64'd10_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ack_i,
    output logic irq_o
);

    localparam int unsigned INTERVAL = int'(cycles_for_period(CLK_FREQ_HZ, PERIOD_US));

    step_e step;
    logic  at_last;
    logic  pending;

    interval_alarm_step u_step (
        .ack_i     (ack_i),
        .pending_i (pending),
        .at_last_i (at_last),
        .step_o    (step)
    );

    interval_alarm_count #(
        .INTERVAL (INTERVAL)
    ) u_count (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .step_i    (step),
        .at_last_o (at_last)
    );

    interval_alarm_flag u_flag (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .step_i    (step),
        .pending_o (pending)
    );

    assign irq_o = pending;

endmodule

// File: rtl/interval_alarm_chk.sv
module interval_alarm_chk #(
    parameter int unsigned LIMIT = 1_000_000,
    localparam int unsigned SW   = $clog2(LIMIT + 1),
    localparam logic [SW-1:0] LIMIT_V = SW'(LIMIT)
) (
    input logic clk_i,
    input logic rst_i,
    input logic ack_i,
    input logic irq_i
);

    // Independent measure of edges since the last restart (reset or ack).
    logic [SW-1:0] since_q;
    logic          rst_seen_q;

    always_ff @(posedge clk_i) begin
        rst_seen_q <= rst_i;
        if (rst_i || ack_i) begin
            since_q <= '0;
        end else if (!irq_i && since_q != LIMIT_V) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R1: one cycle after reset was sampled, the line is low.
    always @(negedge clk_i) begin
        if (rst_seen_q === 1'b1) begin
            assert_low_after_reset_R1: assert (irq_i == 1'b0);
        end
    end

    // R2, R5, R6: the line is high exactly when a full interval has elapsed.
    assert_rise_at_interval_R2: assert property (
        @(posedge clk_i) disable iff (rst_i)
        irq_i == (since_q == LIMIT_V)
    );

    // R3: the level holds until acknowledged.
    assert_hold_until_ack_R3: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (irq_i && !ack_i) |=> irq_i
    );

    // R4, R7, R8: any acknowledge leaves the line low next cycle.
    assert_ack_clears_R4: assert property (
        @(posedge clk_i) disable iff (rst_i)
        ack_i |=> !irq_i
    );

endmodule

bind interval_alarm interval_alarm_chk #(
    .LIMIT (INTERVAL)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ack_i (ack_i),
    .irq_i (irq_o)
);

// File: tb/tb_interval_alarm.sv
`timescale 1ns/1ps
module tb_interval_alarm;

    localparam longint unsigned HZ  = 64'd1_000_000;
    localparam longint unsigned US  = 64'd24;
    localparam int N = int'((HZ * US) / 64'd1_000_000);   // R9: expected 24

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ack = 1'b0;
    logic irq;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    interval_alarm #(
        .CLK_FREQ_HZ (HZ),
        .PERIOD_US   (US)
    ) dut (
        .clk_i (clk),
        .rst_i (rst),
        .ack_i (ack),
        .irq_o (irq)
    );

    // Cycle model written from the requirements.
    int elapsed = 0;
    bit pend    = 1'b0;

    function automatic bit model_irq_next(bit r, bit a, bit p, int e, output int e_n);
        if (r || a) begin
            e_n = 0;
            return 1'b0;
        end
        if (p) begin
            e_n = e;
            return 1'b1;
        end
        e_n = e + 1;
        return (e + 1 == N);
    endfunction

    always @(posedge clk) begin
        int en;
        pend    = model_irq_next(rst, ack, pend, elapsed, en);
        elapsed = en;
    end

    task automatic check(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_int(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: interval actual %0d expected %0d", req, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) check(tag, irq, pend);
    end

    // Count edges from now until irq is seen high (called just after a restart edge).
    task automatic measure(string req, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (irq !== 1'b1 && n < 4 * N);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd1234));

        // R1: reset holds the line low.
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", irq, 1'b0);
        rst = 1'b0;

        // R2 / R9: first interval from reset.
        tag = "R2";
        measure("R2", n);
        check_int("R2", n, N);
        check_int("R9", N, 24);

        // R3: held with no acknowledge.
        tag = "R3";
        repeat (50) begin
            @(negedge clk);
            check("R3", irq, 1'b1);
        end

        // R4: acknowledge clears, next interval from the ack.
        tag = "R4";
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R4", irq, 1'b0);
        measure("R4", n);
        check_int("R4", n, N);

        // R5: a short wait before the acknowledge changes nothing.
        tag = "R5";
        repeat (7) @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        measure("R5", n);
        check_int("R5", n, N);

        // R6: acknowledge mid-interval restarts the count.
        tag = "R6";
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (10) @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        measure("R6", n);
        check_int("R6", n, N);

        // R7: acknowledge held for five cycles.
        tag = "R7";
        ack = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check("R7", irq, 1'b0);
        end
        ack = 1'b0;
        measure("R7", n);
        check_int("R7", n, N);

        // R8: acknowledge on the expiry edge wins.
        tag = "R8";
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (N - 1) @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R8", irq, 1'b0);
        measure("R8", n);
        check_int("R8", n, N);

        // Random acknowledges, compared every cycle against the model (R4, R6).
        tag = "R6";
        for (int i = 0; i < 4000; i++) begin
            ack = (($urandom % 20) == 0);
            @(negedge clk);
        end
        ack = 1'b0;
        repeat (2 * N) @(negedge clk);

        finish_run();
    end

endmodule